// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer data-processing unit of a 32-bit RISC execute stage. It combines a first operand with a second operand that an upstream shifter has already shifted or rotated. A 4-bit opcode selects one of sixteen operations. The operations are bitwise logic, addition and subtraction in normal and reversed operand order, carry-chained forms, and four flag-only forms that compare or test. The block produces the result, an enable that tells the register file whether to write that result, and the next values of the negative, zero, carry and overflow flags.

The block is purely combinational. The barrel shifter, the immediate rotator, the register file and the condition evaluation sit around it. The shifter reports its carry-out together with a valid bit. The valid bit is low when the shift or rotate amount was zero, and in that case the old carry flag is kept. When the set-flags input is low, all four flags pass through untouched.

Top module: `dp_alu`

## Requirements
- R1: With opcodes 0x2 (SUB), 0x4 (ADD), 0x5 (ADC) and 0x6 (SBC), the result is A-B, A+B, A+B+C and A-B+C-1 respectively, modulo 2^32, where C is the incoming carry flag.
- R2: With opcodes 0x3 (RSB) and 0x7 (RSC), the result is B-A and B-A+C-1: the second operand is the minuend.
- R3: With opcodes 0x0 (AND), 0x1 (EOR), 0xC (ORR), 0xD (MOV), 0xE (BIC) and 0xF (MVN), the result is A&B, A^B, A|B, B, A&~B and ~B. MOV and MVN give the same output whatever A holds.
- R4: `reg_write` is low for opcodes 0x8 to 0xB and high for every other opcode.
- R5: When `set_flags` is low, each of the four flag outputs equals its flag input for every opcode.
- R6: When `set_flags` is high, N equals bit 31 of the result, and Z is 1 exactly when the 32-bit result is zero.
- R7: When `set_flags` is high and the operation is arithmetic, C is the carry out of bit 31 of the effective sum. A subtraction is computed as minuend + ~subtrahend + carry-in, so C=1 means no borrow. V is 1 when the signed result overflows 32 bits.
- R8: When `set_flags` is high and the operation is logical (0x0, 0x1, 0x8, 0x9, 0xC to 0xF), C takes `shift_carry` if `shift_carry_valid` is 1 and otherwise keeps its old value. V is unchanged.
- R9: The flag-only forms compute like their counterparts: 0x8 (TST) as AND, 0x9 (TEQ) as EOR, 0xA (CMP) as SUB and 0xB (CMN) as ADD. `result` carries that value and the flags follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| set_flags | input | 1 | Update the condition flags from this operation |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted or rotated |
| shift_carry | input | 1 | Carry out of the shifter or rotator |
| shift_carry_valid | input | 1 | The shifter carry is meaningful (nonzero shift amount) |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| result | output | 32 | Operation result |
| reg_write | output | 1 | Destination register write enable |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| v_out | output | 1 | Next overflow flag |

## Verification
In the carry-chained forms, the incoming carry feeds the adder and the outgoing carry replaces that same flag within one evaluation. A wrong connection here can pass ordinary tests. Directed vectors place ADC and SBC at the wrap points 0xFFFFFFFF+0 and 0-0 with each value of the old carry. Random vectors with both carry values run alongside them. Each output is judged against a bench model that derives carry from unsigned magnitude comparisons and overflow from 64-bit signed arithmetic rather than from an adder.

// File: rtl/dp_alu_pkg.sv
// Package: shared types for the data-processing ALU.
// Assumes a 4-bit opcode in which opcodes 0x8..0xB are the flag-only forms.
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    // Source of the adder carry-in
    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    // Logic unit function
    typedef enum logic [2:0] {
        LOP_AND  = 3'd0,
        LOP_XOR  = 3'd1,
        LOP_OR   = 3'd2,
        LOP_PASS = 3'd3,
        LOP_ANDN = 3'd4,
        LOP_NOT  = 3'd5
    } logic_op_e;

    typedef struct packed {
        logic      is_arith;   // result comes from the adder
        logic      swap;       // adder takes B as minuend / first input
        logic      inv_y;      // adder second input is inverted
        cin_sel_e  cin_sel;    // carry-in source
        logic_op_e lop;        // logic unit function
        logic      writes;     // destination register is written
    } alu_ctl_t;

endpackage

// File: rtl/dp_alu_decode.sv
// Module: dp_alu_decode
// Turns the opcode into control for the adder, the logic unit and the
// write enable. Assumes the opcode map held in dp_alu_pkg.
module dp_alu_decode
    import dp_alu_pkg::*;
(
    input  logic [3:0] op,
    output alu_ctl_t   ctl
);

    // Opcode to control-word table
    always_comb begin
        ctl          = '0;
        ctl.cin_sel  = CIN_ZERO;
        ctl.lop      = LOP_AND;
        ctl.writes   = 1'b1;
        unique case (alu_op_e'(op))
            OP_AND, OP_TST: ctl.lop = LOP_AND;
            OP_EOR, OP_TEQ: ctl.lop = LOP_XOR;
            OP_ORR:         ctl.lop = LOP_OR;
            OP_MOV:         ctl.lop = LOP_PASS;
            OP_BIC:         ctl.lop = LOP_ANDN;
            OP_MVN:         ctl.lop = LOP_NOT;
            OP_SUB, OP_CMP: begin
                ctl.is_arith = 1'b1;
                ctl.inv_y    = 1'b1;
                ctl.cin_sel  = CIN_ONE;
            end
            OP_RSB: begin
                ctl.is_arith = 1'b1;
                ctl.swap     = 1'b1;
                ctl.inv_y    = 1'b1;
                ctl.cin_sel  = CIN_ONE;
            end
            OP_ADD, OP_CMN: ctl.is_arith = 1'b1;
            OP_ADC: begin
                ctl.is_arith = 1'b1;
                ctl.cin_sel  = CIN_FLAG;
            end
            OP_SBC: begin
                ctl.is_arith = 1'b1;
                ctl.inv_y    = 1'b1;
                ctl.cin_sel  = CIN_FLAG;
            end
            OP_RSC: begin
                ctl.is_arith = 1'b1;
                ctl.swap     = 1'b1;
                ctl.inv_y    = 1'b1;
                ctl.cin_sel  = CIN_FLAG;
            end
            default: ;
        endcase
        // flag-only forms share opcode bits 3:2 == 2'b10
        if (op[3:2] == 2'b10) ctl.writes = 1'b0;
    end

endmodule

// File: rtl/dp_alu_adder.sv
// Module: dp_alu_adder
// Single adder for all arithmetic forms: x + (inv ? ~y : y) + cin, with
// optional operand swap. Produces carry out of the top bit and signed
// overflow. Assumes WIDTH >= 2.
module dp_alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             swap,
    input  logic             inv_y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] x;
    logic [WIDTH-1:0] y_eff;
    logic [WIDTH:0]   wide;

    // Operand steering for normal and reversed order
    always_comb begin
        x     = swap ? b : a;
        y_eff = swap ? a : b;
        if (inv_y) y_eff = ~y_eff;
    end

    // Wide sum with carry-in
    always_comb begin
        wide = {1'b0, x} + {1'b0, y_eff} + {{WIDTH{1'b0}}, cin};
        sum  = wide[MSB:0];
        cout = wide[WIDTH];
        ovf  = (x[MSB] == y_eff[MSB]) && (sum[MSB] != x[MSB]);
    end

    // Arithmetic invariants of the adder outputs
    always_comb begin
        if (!x[MSB] && !y_eff[MSB]) begin
            a_r7_no_carry_small: assert (!cout);
        end
        if (x[MSB] != y_eff[MSB]) begin
            a_r7_no_overflow: assert (!ovf);
        end
    end

endmodule

// File: rtl/dp_alu_logic.sv
// Module: dp_alu_logic
// Bitwise unit for the logical forms. Assumes b is the shifted operand.
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_op_e        lop,
    output logic [WIDTH-1:0] y
);

    // Bitwise function select
    always_comb begin
        unique case (lop)
            LOP_AND:  y = a & b;
            LOP_XOR:  y = a ^ b;
            LOP_OR:   y = a | b;
            LOP_PASS: y = b;
            LOP_ANDN: y = a & ~b;
            LOP_NOT:  y = ~b;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu_flags.sv
// Module: dp_alu_flags
// Next-state logic for N, Z, C and V. Arithmetic forms take C and V from
// the adder; logical forms take C from the shifter when valid and keep V.
// Assumes set_flags low means all flags hold.
module dp_alu_flags #(
    parameter int WIDTH = 32
) (
    input  logic             set_flags,
    input  logic             is_arith,
    input  logic [WIDTH-1:0] res,
    input  logic             add_c,
    input  logic             add_v,
    input  logic             sh_c,
    input  logic             sh_c_valid,
    input  logic             n_in,
    input  logic             z_in,
    input  logic             c_in,
    input  logic             v_in,
    output logic             n_out,
    output logic             z_out,
    output logic             c_out,
    output logic             v_out
);

    localparam int MSB = WIDTH - 1;

    // Flag selection by class
    always_comb begin
        n_out = n_in;
        z_out = z_in;
        c_out = c_in;
        v_out = v_in;
        if (set_flags) begin
            n_out = res[MSB];
            z_out = (res == '0);
            if (is_arith) begin
                c_out = add_c;
                v_out = add_v;
            end else if (sh_c_valid) begin
                c_out = sh_c;
            end
        end
    end

    // Flag hold and preservation rules
    always_comb begin
        if (!set_flags) begin
            a_r5_flags_hold: assert ({n_out, z_out, c_out, v_out} ==
                                     {n_in, z_in, c_in, v_in});
        end
        if (set_flags && !is_arith) begin
            a_r8_logic_keeps_v: assert (v_out == v_in);
        end
    end

endmodule

// File: rtl/dp_alu.sv
// Module: dp_alu (top)
// Combinational 32-bit data-processing ALU: decode, one adder, one logic
// unit, result mux and flag logic. Assumes the second operand arrives
// already shifted, with the shifter carry and its valid bit.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic             set_flags,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             shift_carry,
    input  logic             shift_carry_valid,
    input  logic             n_in,
    input  logic             z_in,
    input  logic             c_in,
    input  logic             v_in,
    output logic [WIDTH-1:0] result,
    output logic             reg_write,
    output logic             n_out,
    output logic             z_out,
    output logic             c_out,
    output logic             v_out
);

    alu_ctl_t         ctl;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] lres;
    logic             add_c;
    logic             add_v;
    logic             cin;

    dp_alu_decode u_dec (
        .op  (op),
        .ctl (ctl)
    );

    // Carry-in source select
    always_comb begin
        unique case (ctl.cin_sel)
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = c_in;
            default:  cin = 1'b0;
        endcase
    end

    dp_alu_adder #(.WIDTH(WIDTH)) u_add (
        .a     (opnd_a),
        .b     (opnd_b),
        .swap  (ctl.swap),
        .inv_y (ctl.inv_y),
        .cin   (cin),
        .sum   (sum),
        .cout  (add_c),
        .ovf   (add_v)
    );

    dp_alu_logic #(.WIDTH(WIDTH)) u_log (
        .a   (opnd_a),
        .b   (opnd_b),
        .lop (ctl.lop),
        .y   (lres)
    );

    // Result mux and write enable
    always_comb begin
        result    = ctl.is_arith ? sum : lres;
        reg_write = ctl.writes;
    end

    dp_alu_flags #(.WIDTH(WIDTH)) u_flg (
        .set_flags  (set_flags),
        .is_arith   (ctl.is_arith),
        .res        (result),
        .add_c      (add_c),
        .add_v      (add_v),
        .sh_c       (shift_carry),
        .sh_c_valid (shift_carry_valid),
        .n_in       (n_in),
        .z_in       (z_in),
        .c_in       (c_in),
        .v_in       (v_in),
        .n_out      (n_out),
        .z_out      (z_out),
        .c_out      (c_out),
        .v_out      (v_out)
    );

    // Flag-only forms must never request a register write
    always_comb begin
        if (op[3] && !op[2]) begin
            a_r4_compare_no_write: assert (!reg_write);
        end
    end

endmodule

// File: tb/tb_dp_alu.sv
module tb_dp_alu;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    typedef struct packed {
        logic [31:0] res;
        logic        we;
        logic        n;
        logic        z;
        logic        c;
        logic        v;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic        set_flags = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        shift_carry = 1'b0;
    logic        shift_carry_valid = 1'b0;
    logic        n_in = 1'b0, z_in = 1'b0, c_in = 1'b0, v_in = 1'b0;
    logic [31:0] result;
    logic        reg_write, n_out, z_out, c_out, v_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_alu dut (
        .op(op), .set_flags(set_flags), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shift_carry(shift_carry), .shift_carry_valid(shift_carry_valid),
        .n_in(n_in), .z_in(z_in), .c_in(c_in), .v_in(v_in),
        .result(result), .reg_write(reg_write),
        .n_out(n_out), .z_out(z_out), .c_out(c_out), .v_out(v_out)
    );

    // Reference model built from the requirements
    function automatic exp_t model(input logic [3:0] o, input logic s,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic sc, input logic scv,
                                   input logic n, input logic z,
                                   input logic c, input logic v);
        exp_t e;
        logic [31:0] r;
        logic arith = 1'b1;
        logic co = 1'b0;
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint sr = 0;
        longint ua = longint'({32'd0, a});
        longint ub = longint'({32'd0, b});
        longint cc = longint'(c);
        case (o)
            4'h2, 4'hA: begin r = a - b; co = (ua >= ub); sr = sa - sb; end
            4'h3:       begin r = b - a; co = (ub >= ua); sr = sb - sa; end
            4'h4, 4'hB: begin r = a + b; co = (ua + ub >= 64'sh1_0000_0000); sr = sa + sb; end
            4'h5:       begin r = a + b + {31'd0, c}; co = (ua + ub + cc >= 64'sh1_0000_0000); sr = sa + sb + cc; end
            4'h6:       begin r = a - b + {31'd0, c} - 32'd1; co = (ua + cc >= ub + 1); sr = sa - sb + cc - 1; end
            4'h7:       begin r = b - a + {31'd0, c} - 32'd1; co = (ub + cc >= ua + 1); sr = sb - sa + cc - 1; end
            4'h0, 4'h8: begin r = a & b;  arith = 1'b0; end
            4'h1, 4'h9: begin r = a ^ b;  arith = 1'b0; end
            4'hC:       begin r = a | b;  arith = 1'b0; end
            4'hD:       begin r = b;      arith = 1'b0; end
            4'hE:       begin r = a & ~b; arith = 1'b0; end
            default:    begin r = ~b;     arith = 1'b0; end
        endcase
        e.res = r;
        e.we  = !(o >= 4'h8 && o <= 4'hB);
        if (!s) begin
            e.n = n; e.z = z; e.c = c; e.v = v;
        end else begin
            e.n = r[31];
            e.z = (r == 32'd0);
            if (arith) begin
                e.c = co;
                e.v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end else begin
                e.c = scv ? sc : c;
                e.v = v;
            end
        end
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%h act=%h exp=%h", tag, op, act, exp);
        end
    endtask

    // Drive one vector on a rising edge, check on the following falling edge
    task automatic apply(input logic [3:0] o, input logic s,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic scv,
                         input logic [3:0] nzcv);
        exp_t e;
        string rtag;
        @(posedge clk);
        op = o; set_flags = s; opnd_a = a; opnd_b = b;
        shift_carry = sc; shift_carry_valid = scv;
        {n_in, z_in, c_in, v_in} = nzcv;
        @(negedge clk);
        e = model(o, s, a, b, sc, scv, nzcv[3], nzcv[2], nzcv[1], nzcv[0]);
        if (o >= 4'h8 && o <= 4'hB)        rtag = "R9";
        else if (o == 4'h3 || o == 4'h7)   rtag = "R2";
        else if (o >= 4'h2 && o <= 4'h6)   rtag = "R1";
        else                               rtag = "R3";
        chk(rtag, result, e.res);
        chk("R4", {31'd0, reg_write}, {31'd0, e.we});
        if (!s) begin
            chk("R5", {28'd0, n_out, z_out, c_out, v_out},
                      {28'd0, e.n, e.z, e.c, e.v});
        end else begin
            chk("R6", {30'd0, n_out, z_out}, {30'd0, e.n, e.z});
            if ((o >= 4'h2 && o <= 4'h7) || o == 4'hA || o == 4'hB)
                chk("R7", {30'd0, c_out, v_out}, {30'd0, e.c, e.v});
            else
                chk("R8", {30'd0, c_out, v_out}, {30'd0, e.c, e.v});
        end
    endtask

    function automatic logic [31:0] pick();
        logic [31:0] r;
        case ($urandom_range(0, 7))
            0: r = 32'h0000_0000;
            1: r = 32'hFFFF_FFFF;
            2: r = 32'h7FFF_FFFF;
            3: r = 32'h8000_0000;
            4: r = 32'h0000_0001;
            default: r = $urandom;
        endcase
        return r;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // initial state: all-zero inputs give AND of zeros, write high, flags held
        @(negedge clk);
        chk("R3", result, 32'd0);
        chk("R4", {31'd0, reg_write}, 32'd1);
        chk("R5", {28'd0, n_out, z_out, c_out, v_out}, 32'd0);

        // R1 carry chain at the wrap points, both old carry values
        apply(4'h5, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 4'b0010);
        apply(4'h5, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 4'b0000);
        apply(4'h6, 1'b1, 32'h0, 32'h0, 1'b0, 1'b0, 4'b0000);
        apply(4'h6, 1'b1, 32'h0, 32'h0, 1'b0, 1'b0, 4'b0010);
        // R7 signed overflow on ADD and SUB
        apply(4'h4, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 4'b0000);
        apply(4'h2, 1'b1, 32'h8000_0000, 32'h1, 1'b0, 1'b0, 4'b0000);
        // R2 reverse forms
        apply(4'h3, 1'b1, 32'd5, 32'd3, 1'b0, 1'b0, 4'b0000);
        apply(4'h7, 1'b1, 32'd3, 32'd5, 1'b0, 1'b0, 4'b0000);
        // R3 MVN and MOV ignore the first operand
        apply(4'hF, 1'b0, 32'h1234_5678, 32'h00FF_00FF, 1'b0, 1'b0, 4'b0000);
        apply(4'hF, 1'b0, 32'hDEAD_BEEF, 32'h00FF_00FF, 1'b0, 1'b0, 4'b0000);
        apply(4'hD, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1, 4'b0001);
        // R8 logical carry: valid shifter carry used, invalid keeps old C
        apply(4'h9, 1'b1, 32'hF0F0, 32'hF0F0, 1'b0, 1'b0, 4'b0011);
        apply(4'h9, 1'b1, 32'hF0F0, 32'hF0F0, 1'b0, 1'b1, 4'b0011);
        // R9 compare of equal values: Z and C set, no write
        apply(4'hA, 1'b1, 32'd77, 32'd77, 1'b0, 1'b0, 4'b0000);
        apply(4'hB, 1'b1, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 4'b0000);
        apply(4'h8, 1'b1, 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 1'b1, 4'b1000);
        // R5 flags held with set_flags low on an overflowing add
        apply(4'h4, 1'b0, 32'h7FFF_FFFF, 32'h1, 1'b1, 1'b1, 4'b1010);

        for (int i = 0; i < N_RANDOM; i++) begin
            apply(4'($urandom_range(0, 15)), 1'($urandom), pick(), pick(),
                  1'($urandom), 1'($urandom), 4'($urandom));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule